// File: doc/BRIEF.md
# Memory-Mapped 64-bit Compare Timer

This peripheral holds a free-running 64-bit up-counter behind an 8-bit clock divider and a 64-bit comparator. Software reaches every register over a plain 32-bit register port: one address, a write strobe, write data and registered read data. Wide values are read and written as a low and a high 32-bit half. When the counter reaches or passes the comparator value, the block raises a sticky event flag. It also drives an interrupt line when interrupts are enabled.

For one-shot deadlines, software first turns off the comparator. It then loads the new comparator halves and turns the comparator back on. The turned-off comparator cannot raise the flag during those writes. For periodic ticks, the auto-advance bit makes every hit add a 32-bit step to the comparator, so the next event follows one step later without software help. A deadline that has already passed when the comparator is turned on still fires, because the match is greater-than-or-equal.

Top module: `ctm_timer_top`

## Requirements
- R1: After reset, every register reads as zero and `irq_o` is 0.
- R2: Registers sit at byte addresses 0x00 counter low, 0x04 counter high, 0x08 control, 0x0C status, 0x10 comparator low, 0x14 comparator high and 0x18 step. Read data appears on the clock after the address. Unmapped or misaligned addresses read as zero. Control bits 7:4 and 31:16 always read as zero.
- R3: The control bits are: bit 0 runs the counter, bit 1 arms the comparator, bit 2 enables the interrupt, bit 3 enables auto-advance, and bits 15:8 hold a divider value P. While running, the counter advances once every P+1 clocks. Counting starts from a fresh divider phase each time the counter is enabled.
- R4: Writes to the counter halves take effect only while control bit 0 is 0. While the counter runs, such writes are ignored.
- R5: The counter is a true 64-bit value, and a carry out of the low half increments the high half.
- R6: While control bit 1 is 1, a counter value greater than or equal to the comparator sets status bit 0 on the following clock. This also holds when the comparator is armed after the deadline has passed.
- R7: While control bit 1 is 0, status bit 0 is never set, whatever the counter and comparator values are.
- R8: Status bit 0 is sticky. Writing 1 to it clears it, and writing 0 has no effect. It is not set again while the same match simply persists. A new hit in the same cycle as a clear wins.
- R9: `irq_o` is a registered copy of status bit 0 AND control bit 2. It rises on the clock after the flag, two clocks after the counter reaches the comparator.
- R10: With control bit 3 set, every hit adds the zero-extended step register to the comparator. Back-to-back hits repeat until the comparator exceeds the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Byte address of the register access |
| bus_we | input | 1 | Write strobe for this cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| irq_o | output | 1 | Registered interrupt request |

## Verification
Each result has a fixed latency, and the bench samples it exactly there.

- **Read data:** valid one clock after the address is presented.
- **Counter:** after the enabling write, a run of N clocks with the counter on gives floor(N/(P+1)) counts. The bench counts every rising edge between the enabling and disabling writes.
- **Flag and interrupt:** the flag is set one clock after the counter reaches the comparator, and `irq_o` follows one clock later.

Inputs are driven and outputs sampled on falling edges. For auto-advance, expected comparator values are computed arithmetically over a sweep of divider and step values.

// File: rtl/ctm_pkg.sv
package ctm_pkg;
  // word indices of the register map (byte address >> 2)
  localparam int IDX_CNT_LO = 0;
  localparam int IDX_CNT_HI = 1;
  localparam int IDX_CTRL   = 2;
  localparam int IDX_STAT   = 3;
  localparam int IDX_CMP_LO = 4;
  localparam int IDX_CMP_HI = 5;
  localparam int IDX_STEP   = 6;
  localparam int NUM_REGS   = 7;

  // control field positions
  localparam int BIT_RUN    = 0;
  localparam int BIT_ARM    = 1;
  localparam int BIT_IRQ    = 2;
  localparam int BIT_AUTO   = 3;
  localparam int DIV_LSB    = 8;

  // status field position
  localparam int BIT_FLAG   = 0;
endpackage

// File: rtl/ctm_prescaler.sv
module ctm_prescaler #(
  parameter int PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [PSC_W-1:0] divisor,
  output logic             tick
);
  logic [PSC_W-1:0] phase_q;

  // >= keeps the divider safe when the divisor is lowered mid-phase
  assign tick = enable && (phase_q >= divisor);

  always_ff @(posedge clk) begin
    if (rst || !enable) phase_q <= '0;
    else if (tick)      phase_q <= '0;
    else                phase_q <= phase_q + 1'b1;
  end

  // R3
  tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    (enable && tick && divisor != '0) |=> (!tick || divisor != $past(divisor)));
endmodule

// File: rtl/ctm_counter.sv
module ctm_counter #(
  parameter int DATA_W = 32,
  parameter int HALVES = 2,
  localparam int CNT_W = DATA_W * HALVES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              tick,
  input  logic [HALVES-1:0] wr_half,
  input  logic [DATA_W-1:0] wdata,
  output logic [CNT_W-1:0]  count
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (enable) begin
      if (tick) cnt_d = cnt_q + 1'b1;
    end else begin
      for (int h = 0; h < HALVES; h++)
        if (wr_half[h]) cnt_d[h*DATA_W +: DATA_W] = wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  // R4
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!enable && wr_half == '0) |=> $stable(cnt_q));
  // R3
  cnt_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (enable && !tick) |=> $stable(cnt_q));
endmodule

// File: rtl/ctm_compare.sv
module ctm_compare #(
  parameter int DATA_W = 32,
  parameter int HALVES = 2,
  localparam int CNT_W = DATA_W * HALVES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  count,
  input  logic              arm,
  input  logic              auto_en,
  input  logic [HALVES-1:0] wr_half,
  input  logic              wr_step,
  input  logic [DATA_W-1:0] wdata,
  input  logic              clr,
  output logic [CNT_W-1:0]  cmp_val,
  output logic [DATA_W-1:0] step_val,
  output logic              flag
);
  logic [CNT_W-1:0]  cmp_q, cmp_d;
  logic [DATA_W-1:0] step_q;
  logic              blk_q, flag_q, match, hit;

  assign match = (count >= cmp_q);
  // one event per new match; an auto-advance re-opens the window
  assign hit   = arm && match && !blk_q;

  always_comb begin
    cmp_d = cmp_q;
    if (wr_half != '0) begin
      for (int h = 0; h < HALVES; h++)
        if (wr_half[h]) cmp_d[h*DATA_W +: DATA_W] = wdata;
    end else if (hit && auto_en) begin
      cmp_d = cmp_q + CNT_W'(step_q);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q  <= '0;
      step_q <= '0;
      blk_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      cmp_q <= cmp_d;
      if (wr_step) step_q <= wdata;
      blk_q <= arm && match && !(hit && auto_en);
      if (hit)      flag_q <= 1'b1;
      else if (clr) flag_q <= 1'b0;
    end
  end

  assign cmp_val  = cmp_q;
  assign step_val = step_q;
  assign flag     = flag_q;

  // R7
  flag_needs_arm_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> $past(arm));
  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !clr) |=> flag_q);
  // R10
  auto_step_chk: assert property (@(posedge clk) disable iff (rst)
    (hit && auto_en && wr_half == '0) |=> cmp_q == $past(cmp_q) + CNT_W'($past(step_q)));
endmodule

// File: rtl/ctm_timer_top.sv
module ctm_timer_top #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int PSC_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);
  import ctm_pkg::*;

  localparam int HALVES = 2;
  localparam int CNT_W  = DATA_W * HALVES;
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0]   word;
  logic                aligned;
  logic [NUM_REGS-1:0] sel, wr;

  assign word    = bus_addr[ADDR_W-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_dec
    assign sel[i] = aligned && (word == WORD_W'(i));
    assign wr[i]  = sel[i] && bus_we;
  end

  // control register
  logic             run_q, arm_q, irqen_q, auto_q;
  logic [PSC_W-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0; arm_q <= 1'b0; irqen_q <= 1'b0; auto_q <= 1'b0;
      div_q <= '0;
    end else if (wr[IDX_CTRL]) begin
      run_q   <= bus_wdata[BIT_RUN];
      arm_q   <= bus_wdata[BIT_ARM];
      irqen_q <= bus_wdata[BIT_IRQ];
      auto_q  <= bus_wdata[BIT_AUTO];
      div_q   <= bus_wdata[DIV_LSB +: PSC_W];
    end
  end

  logic             tick, flag;
  logic [CNT_W-1:0] count, cmp_val;
  logic [DATA_W-1:0] step_val;

  ctm_prescaler #(.PSC_W(PSC_W)) u_div (
    .clk(clk), .rst(rst), .enable(run_q), .divisor(div_q), .tick(tick)
  );

  ctm_counter #(.DATA_W(DATA_W), .HALVES(HALVES)) u_cnt (
    .clk(clk), .rst(rst), .enable(run_q), .tick(tick),
    .wr_half({wr[IDX_CNT_HI], wr[IDX_CNT_LO]}), .wdata(bus_wdata),
    .count(count)
  );

  ctm_compare #(.DATA_W(DATA_W), .HALVES(HALVES)) u_cmp (
    .clk(clk), .rst(rst), .count(count), .arm(arm_q), .auto_en(auto_q),
    .wr_half({wr[IDX_CMP_HI], wr[IDX_CMP_LO]}), .wr_step(wr[IDX_STEP]),
    .wdata(bus_wdata), .clr(wr[IDX_STAT] && bus_wdata[BIT_FLAG]),
    .cmp_val(cmp_val), .step_val(step_val), .flag(flag)
  );

  // registered read path
  logic [DATA_W-1:0] rd_d, ctrl_rd;

  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[BIT_RUN]  = run_q;
    ctrl_rd[BIT_ARM]  = arm_q;
    ctrl_rd[BIT_IRQ]  = irqen_q;
    ctrl_rd[BIT_AUTO] = auto_q;
    ctrl_rd[DIV_LSB +: PSC_W] = div_q;
  end

  always_comb begin
    rd_d = '0;
    if (sel[IDX_CNT_LO]) rd_d = count[DATA_W-1:0];
    if (sel[IDX_CNT_HI]) rd_d = count[CNT_W-1:DATA_W];
    if (sel[IDX_CTRL])   rd_d = ctrl_rd;
    if (sel[IDX_STAT])   rd_d = DATA_W'(flag);
    if (sel[IDX_CMP_LO]) rd_d = cmp_val[DATA_W-1:0];
    if (sel[IDX_CMP_HI]) rd_d = cmp_val[CNT_W-1:DATA_W];
    if (sel[IDX_STEP])   rd_d = step_val;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_o     <= 1'b0;
    end else begin
      bus_rdata <= rd_d;
      irq_o     <= flag && irqen_q;
    end
  end

  // R9
  irq_source_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(flag && irqen_q));
  // R2
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $past(sel == '0) |-> bus_rdata == '0);
endmodule

// File: tb/tb_ctm_timer_top.sv
module tb_ctm_timer_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int total = 0;
  int bad = 0;

  localparam logic [4:0] A_CLO = 5'h00, A_CHI = 5'h04, A_CTL = 5'h08,
                         A_STA = 5'h0C, A_MLO = 5'h10, A_MHI = 5'h14,
                         A_STP = 5'h18;

  always #4 clk = ~clk;

  ctm_timer_top dut (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_we(we),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    addr = a; we = 1'b0;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic rd64(input logic [4:0] a, output logic [63:0] d);
    logic [31:0] lo, hi;
    rd(a, lo);
    rd(a + 5'd4, hi);
    d = {hi, lo};
  endtask

  task automatic load_cnt(input logic [63:0] v);
    wr(A_CTL, 32'h0);
    wr(A_CLO, v[31:0]);
    wr(A_CHI, v[63:32]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [63:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk("R1 irq", {63'd0, irq}, 64'd0);
    for (int a = 0; a < 7; a++) begin
      rd(5'(a * 4), r);
      chk("R1 reg", {32'd0, r}, 64'd0);
    end

    // R2: control masking, unmapped and misaligned reads
    wr(A_CTL, 32'hABCD_12F0);
    rd(A_CTL, r); chk("R2 ctrl mask", {32'd0, r}, 64'h1200);
    wr(A_STP, 32'h0000_0077);
    rd(5'h1C, r); chk("R2 unmapped", {32'd0, r}, 64'd0);
    rd(5'h19, r); chk("R2 misaligned", {32'd0, r}, 64'd0);
    rd(A_STP, r); chk("R10 step readback", {32'd0, r}, 64'h77);

    // R3: divider sweep, N active edges give floor(N/(P+1))
    for (int p = 0; p < 5; p++) begin
      for (int k = 0; k < 2; k++) begin
        int w;
        w = (k == 0) ? 7 : 12;
        load_cnt(64'd0);
        wr(A_CTL, 32'(p) << 8 | 32'h1);
        idle(w);
        wr(A_CTL, 32'(p) << 8);
        rd64(A_CLO, v);
        chk("R3 divider", v, 64'((w + 1) / (p + 1)));
      end
    end

    // R5: carry across halves
    load_cnt(64'h5_FFFF_FFFE);
    wr(A_CTL, 32'h1);
    idle(2);
    wr(A_CTL, 32'h0);
    rd64(A_CLO, v);
    chk("R5 carry", v, 64'h6_0000_0001);

    // R4: counter writes ignored while running
    load_cnt(64'd0);
    wr(A_CTL, 32'h1);
    wr(A_CLO, 32'h1234);
    wr(A_CHI, 32'h99);
    wr(A_CTL, 32'h0);
    rd64(A_CLO, v);
    chk("R4 write ignored", v, 64'd3);

    // R7: no event while comparator disarmed during reprogramming
    load_cnt(64'd100);
    wr(A_CTL, 32'h4);
    wr(A_MLO, 32'd50);
    wr(A_MHI, 32'd0);
    idle(3);
    rd(A_STA, r); chk("R7 no flag disarmed", {32'd0, r}, 64'd0);
    chk("R7 no irq", {63'd0, irq}, 64'd0);

    // R6/R9: arming after a passed deadline fires; irq one clock after flag
    wr(A_CTL, 32'h6);
    idle(1);
    chk("R9 irq not yet", {63'd0, irq}, 64'd0);
    idle(1);
    chk("R9 irq up", {63'd0, irq}, 64'd1);
    rd(A_STA, r); chk("R6 ge flag", {32'd0, r}, 64'd1);

    // R8: write 0 no effect, write 1 clears, no refire on held match
    wr(A_STA, 32'h0);
    rd(A_STA, r); chk("R8 write0", {32'd0, r}, 64'd1);
    wr(A_STA, 32'h1);
    idle(2);
    rd(A_STA, r); chk("R8 clear", {32'd0, r}, 64'd0);
    chk("R8 irq drop", {63'd0, irq}, 64'd0);

    // R6/R9: exact timing with a running counter (cnt==10 at edge E0+10)
    load_cnt(64'd0);
    wr(A_MLO, 32'd10);
    wr(A_MHI, 32'd0);
    wr(A_STA, 32'h1);
    wr(A_CTL, 32'h7);
    idle(11);
    chk("R9 irq at k+1", {63'd0, irq}, 64'd0);
    idle(1);
    chk("R9 irq at k+2", {63'd0, irq}, 64'd1);
    wr(A_CTL, 32'h0);
    rd(A_STA, r); chk("R6 equal hit", {32'd0, r}, 64'd1);

    // R9: irq gated by enable bit
    load_cnt(64'd100);
    wr(A_MLO, 32'd50);
    wr(A_STA, 32'h1);
    wr(A_CTL, 32'h2);
    idle(3);
    chk("R9 gated", {63'd0, irq}, 64'd0);
    rd(A_STA, r); chk("R6 flag gated", {32'd0, r}, 64'd1);
    wr(A_CTL, 32'h6);
    idle(1);
    chk("R9 ungated", {63'd0, irq}, 64'd1);

    // R10: auto-advance sweep over divider and step
    for (int p = 0; p < 4; p++) begin
      for (int s = 1; s < 5; s++) begin
        int n, c;
        logic [63:0] e;
        c = 5;
        n = 21 / (p + 1);
        e = (c > n) ? 64'(c) : 64'(c + s * ((n - c) / s + 1));
        load_cnt(64'd0);
        wr(A_MLO, 32'(c));
        wr(A_MHI, 32'd0);
        wr(A_STP, 32'(s));
        wr(A_STA, 32'h1);
        wr(A_CTL, 32'(p) << 8 | 32'hB);
        idle(20);
        wr(A_CTL, 32'(p) << 8 | 32'hA);
        idle(4);
        rd64(A_MLO, v);
        chk("R10 auto cmp", v, e);
        rd(A_STA, r);
        chk("R10 auto flag", {32'd0, r}, (c > n) ? 64'd0 : 64'd1);
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule